// File: doc/BRIEF.md
# Flash program/erase pulse timer

This block sets the length of the high-voltage pulse used when a flash cell array is programmed or erased. It runs from the system clock. A three-bit range code picks a prescale ratio R from 1, 3/2, 2, 3 or 4. The aim is a base tick of roughly 83 to 125 ns at the system clock in use. The pulse lasts R × 2^N × M system clocks. The exponent N is 5 plus a two-bit exponent code, plus 10 more when erase mode is selected. The multiplier M is one more than a seven-bit code.

A start request taken while idle latches the range, exponent, multiplier and mode inputs. Those latched values then fix the whole operation. `pulse_o` rises on the next clock edge and stays high for the computed number of clocks. A fixed recovery window of 128 system clocks follows. A one-cycle `done_o` strobe ends the operation. `busy_o` covers both the pulse and the recovery window. A start request carrying a reserved range code is refused and flagged on `err_o`. The block does not watch the clock frequency. Keeping the clock within the selected range is the user's job.

Top module: `flash_pulse_timer`

## Requirements
- R1: While reset is held and right after it, `pulse_o`, `busy_o`, `done_o` and `err_o` are all 0.
- R2: A start request accepted in idle raises `pulse_o` on the next clock edge, and it stays high for exactly R × 2^N × M clocks. The range code gives R as follows: 3'b001 → 1, 3'b011 → 2, 3'b100 → 3, 3'b101 → 4.
- R3: Range code 3'b010 gives R = 3/2. Base ticks come alternately two clocks and one clock apart, so the pulse is exactly 3/2 × 2^N × M clocks.
- R4: N = 5 + `exp_sel_i` when `erase_i` = 0. N = 15 + `exp_sel_i` when `erase_i` = 1.
- R5: M = 1 + `mult_sel_i`, giving a range of 1 to 128.
- R6: After `pulse_o` falls, `busy_o` stays high with `pulse_o` low for exactly 128 more clocks.
- R7: `done_o` is high for exactly one clock, the first clock after the recovery window. `busy_o` is 0 in that clock.
- R8: A start request with range code 3'b000, 3'b110 or 3'b111 produces no pulse and no busy, and sets `err_o` from the next edge onward. `err_o` clears when a start request is next accepted.
- R9: Start requests that arrive while `busy_o` is high have no effect on the running operation or on `err_o`.
- R10: Changes to the range, exponent, multiplier or mode inputs after the accepting edge do not change the length of the running pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on each rising edge |
| range_sel_i | input | 3 | Clock range code selecting R |
| exp_sel_i | input | 2 | Exponent code added to N |
| mult_sel_i | input | 7 | Multiplier code, M = code + 1 |
| erase_i | input | 1 | 1 = erase (adds 10 to N), 0 = program |
| pulse_o | output | 1 | High-voltage pulse enable |
| busy_o | output | 1 | High from the accepting edge until recovery ends |
| done_o | output | 1 | One-clock strobe after recovery |
| err_o | output | 1 | Last start request was refused for a reserved range code |

## Verification
A fault in the prescaler phase or in the tick counter shows up as a pulse edge that falls too early or too late. A reference model that tracks every clock catches it on the first cycle where `pulse_o` disagrees. The fractional 3/2 ratio only gives the correct length if the tick falls at the end of each uneven interval. A miscount in the recovery counter moves the `busy_o` fall and the `done_o` strobe by the same number of clocks. A latched configuration that leaks through from the live inputs changes the pulse length only when the inputs move during a pulse. The bench therefore changes them in that window.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RECOV = 2'd2
  } fpt_state_e;

  // period: clocks per prescaler cycle; frac: two ticks per cycle (R = 3/2)
  typedef struct packed {
    logic [2:0] period;
    logic       frac;
  } fpt_scale_t;

  function automatic logic range_ok(input logic [2:0] code);
    return (code >= 3'b001) && (code <= 3'b101);
  endfunction

  function automatic fpt_scale_t range_decode(input logic [2:0] code);
    fpt_scale_t s;
    s.frac = 1'b0;
    unique case (code)
      3'b001:  s.period = 3'd1;
      3'b010:  begin s.period = 3'd3; s.frac = 1'b1; end
      3'b011:  s.period = 3'd2;
      3'b100:  s.period = 3'd3;
      3'b101:  s.period = 3'd4;
      default: s.period = 3'd1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fpt_prescaler.sv
module fpt_prescaler
  import fpt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  fpt_scale_t scale_i,
  output logic       tick_o
);

  logic [2:0] phase_q;
  logic       wrap;

  assign wrap = (phase_q == scale_i.period - 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (!run_i) phase_q <= '0;
    else if (wrap)   phase_q <= '0;
    else             phase_q <= phase_q + 3'd1;
  end

  // tick sits at the end of each interval: fractional mode ticks on phases 1 and 2
  always_comb begin
    if (!run_i)            tick_o = 1'b0;
    else if (scale_i.frac) tick_o = (phase_q != 3'd0);
    else                   tick_o = wrap;
  end

  // R2
  no_double_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !scale_i.frac && scale_i.period >= 3'd2 && tick_o) |=> !tick_o);

  // R3
  frac_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && scale_i.frac && phase_q == 3'd0) |-> !tick_o);

endmodule

// File: rtl/fpt_tick_counter.sv
module fpt_tick_counter #(
  parameter int unsigned CNT_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = tick_i && (cnt_q == target_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> (cnt_q < target_i));

endmodule

// File: rtl/fpt_recovery.sv
module fpt_recovery #(
  parameter int unsigned RECOV_CYC = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic end_o
);

  localparam int unsigned RC_W = (RECOV_CYC > 1) ? $clog2(RECOV_CYC) : 1;

  logic [RC_W-1:0] cnt_q;

  assign end_o = run_i && (cnt_q == RC_W'(RECOV_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + RC_W'(1);
  end

  // R6
  recov_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (32'(cnt_q) < RECOV_CYC));

endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer
  import fpt_pkg::*;
#(
  parameter int unsigned MULT_W    = 7,
  parameter int unsigned EXP_W     = 2,
  parameter int unsigned BASE_EXP  = 5,
  parameter int unsigned ERASE_EXP = 10,
  parameter int unsigned RECOV_CYC = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        range_sel_i,
  input  logic [EXP_W-1:0]  exp_sel_i,
  input  logic [MULT_W-1:0] mult_sel_i,
  input  logic              erase_i,
  output logic              pulse_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int unsigned MAX_SH = BASE_EXP + (2**EXP_W - 1) + ERASE_EXP;
  localparam int unsigned CNT_W  = MULT_W + 1 + MAX_SH;
  localparam int unsigned SH_W   = $clog2(MAX_SH + 1);

  fpt_state_e       state_q;
  fpt_scale_t       scale_q;
  logic [CNT_W-1:0] target_q;
  logic             done_q, err_q;
  logic             tick, last_tick, recov_end, accept;
  logic [SH_W-1:0]  shamt;
  logic [CNT_W-1:0] mult_ext;

  assign accept   = (state_q == ST_IDLE) && start_i && range_ok(range_sel_i);
  assign shamt    = SH_W'(BASE_EXP) + SH_W'(exp_sel_i) + (erase_i ? SH_W'(ERASE_EXP) : '0);
  assign mult_ext = CNT_W'(mult_sel_i) + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      scale_q  <= '0;
      target_q <= CNT_W'(1);
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (range_ok(range_sel_i)) begin
              state_q  <= ST_PULSE;
              scale_q  <= range_decode(range_sel_i);
              target_q <= mult_ext << shamt;
              err_q    <= 1'b0;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_PULSE: if (last_tick) state_q <= ST_RECOV;
        ST_RECOV: if (recov_end) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fpt_prescaler u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_PULSE),
    .scale_i (scale_q),
    .tick_o  (tick)
  );

  fpt_tick_counter #(.CNT_W(CNT_W)) u_ticks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (state_q != ST_PULSE),
    .tick_i   (tick),
    .target_i (target_q),
    .last_o   (last_tick)
  );

  fpt_recovery #(.RECOV_CYC(RECOV_CYC)) u_recov (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_RECOV),
    .end_o  (recov_end)
  );

  assign pulse_o = (state_q == ST_PULSE);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;

  // R8
  refused_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !range_ok(range_sel_i)) |=> (!busy_o && err_o));

  // R6
  recov_follows_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> (busy_o && !done_o));

  // R7
  done_after_recov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && !$past(pulse_o)));

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && $past(pulse_o)) |-> ($stable(target_q) && $stable(scale_q)));

  // R9
  busy_err_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(err_o));

endmodule

// File: tb/flash_pulse_timer_bench.sv
`timescale 1ns/1ps
module flash_pulse_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] range_sel = 3'b001;
  logic [1:0] exp_sel = '0;
  logic [6:0] mult_sel = '0;
  logic       erase = 1'b0;
  logic       pulse, busy, done, err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int pulse_cnt = 0;

  // reference model state
  longint m_pulse_left = 0;
  int     m_rec_left = 0;
  bit     m_done = 0;
  bit     m_err = 0;

  always #4 clk = ~clk;

  flash_pulse_timer u_flash_pulse_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .range_sel_i (range_sel),
    .exp_sel_i   (exp_sel),
    .mult_sel_i  (mult_sel),
    .erase_i     (erase),
    .pulse_o     (pulse),
    .busy_o      (busy),
    .done_o      (done),
    .err_o       (err)
  );

  function automatic longint pulse_len(input logic [2:0] r, input int e, input int m, input bit er);
    longint t;
    t = longint'(m + 1) << (5 + e + (er ? 10 : 0));
    case (r)
      3'b001:  return t;
      3'b010:  return (t * 3) / 2;
      3'b011:  return t * 2;
      3'b100:  return t * 3;
      3'b101:  return t * 4;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pulse_left = 0; m_rec_left = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0;
      if (m_pulse_left > 0) begin
        m_pulse_left--;
        if (m_pulse_left == 0) m_rec_left = 128;
      end else if (m_rec_left > 0) begin
        m_rec_left--;
        if (m_rec_left == 0) m_done = 1;
      end else if (start) begin
        if (range_sel >= 3'b001 && range_sel <= 3'b101) begin
          m_pulse_left = pulse_len(range_sel, int'(exp_sel), int'(mult_sel), erase);
          m_err = 0;
        end else begin
          m_err = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    check(pulse == (m_pulse_left > 0), "R2 pulse", pulse, m_pulse_left > 0);
    check(busy == (m_pulse_left > 0 || m_rec_left > 0), "R6 busy", busy,
          m_pulse_left > 0 || m_rec_left > 0);
    check(done == m_done, "R7 done", done, m_done);
    check(err == m_err, "R8 err", err, m_err);
    if (pulse) pulse_cnt++;
  end

  always @(negedge clk) begin
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic kick(input logic [2:0] r, input logic [1:0] e, input logic [6:0] m, input bit er);
    @(negedge clk);
    pulse_cnt = 0;
    range_sel = r; exp_sel = e; mult_sel = m; erase = er; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] r, input logic [1:0] e, input logic [6:0] m,
                        input bit er, input string req);
    longint want;
    want = pulse_len(r, int'(e), int'(m), er);
    kick(r, e, m, er);
    while (busy) @(negedge clk);
    check(pulse_cnt == want, req, pulse_cnt, want);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!pulse && !busy && !done && !err, "R1 reset outputs", {pulse, busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pulse && !busy && !done && !err, "R1 after release", {pulse, busy, done, err}, 0);

    run_op(3'b001, 2'd0, 7'd0,   1'b0, "R2 R=1 length");
    run_op(3'b010, 2'd0, 7'd2,   1'b0, "R3 R=3/2 length");
    run_op(3'b010, 2'd1, 7'd0,   1'b0, "R3 R=3/2 exp1 length");
    run_op(3'b011, 2'd1, 7'd1,   1'b0, "R4 exponent length");
    run_op(3'b100, 2'd0, 7'd4,   1'b0, "R5 multiplier length");
    run_op(3'b101, 2'd0, 7'd0,   1'b0, "R2 R=4 length");
    run_op(3'b001, 2'd0, 7'd127, 1'b0, "R5 max multiplier length");
    run_op(3'b001, 2'd3, 7'd0,   1'b0, "R4 max program exponent");
    run_op(3'b001, 2'd0, 7'd0,   1'b1, "R4 erase exponent length");

    // R8: reserved codes refused
    kick(3'b000, 2'd0, 7'd0, 1'b0);
    check(err && !busy, "R8 code 000 refused", {err, busy}, 2'b10);
    kick(3'b110, 2'd0, 7'd0, 1'b0);
    check(err && !busy, "R8 code 110 refused", {err, busy}, 2'b10);
    kick(3'b111, 2'd0, 7'd0, 1'b0);
    check(err && !busy, "R8 code 111 refused", {err, busy}, 2'b10);
    kick(3'b011, 2'd0, 7'd0, 1'b0);
    check(!err && busy, "R8 err cleared by accepted start", {err, busy}, 2'b01);
    while (busy) @(negedge clk);

    // R9 + R10: restarts and config changes while busy
    kick(3'b011, 2'd0, 7'd3, 1'b0);
    repeat (20) @(negedge clk);
    range_sel = 3'b101; exp_sel = 2'd3; mult_sel = 7'd99; erase = 1'b1; start = 1'b1;
    repeat (10) @(negedge clk);
    range_sel = 3'b111; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (pulse) @(negedge clk);
    check(pulse_cnt == 256, "R10 pulse length held", pulse_cnt, 256);
    start = 1'b1; range_sel = 3'b000;
    repeat (5) @(negedge clk);
    start = 1'b0;
    check(!err && busy, "R9 start in recovery ignored", {err, busy}, 2'b01);
    while (busy) @(negedge clk);
    check(pulse_cnt == 256, "R9 single pulse only", pulse_cnt, 256);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule